// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Reduced Instruction Set

This block is the serial test port of a memory device. A four-wire test bus of clock, mode select, serial in and serial out steers a sixteen-state controller. That controller chooses between a 3-bit instruction path and one of three data paths: a single-bit pass-through stage, a 32-bit identification word, and a boundary register that holds a snapshot of the device pins. The block has no separate test-reset pin. A power-up reset, synchronous and active low, puts the controller in its reset state, and holding mode select high for five clocks returns it there from any state.

The instruction decoder knows only a few operations. Two opcodes take a pin snapshot and also tell the data output drivers to float, so that every input can be observed undisturbed. A third opcode takes a snapshot and leaves the drivers alone. The other opcodes select the identification word or the pass-through stage. The codes that are kept for private use fall back to the pass-through stage, so a chain of devices keeps working. Serial out is launched on the falling edge of the test clock and is driven only while a register is being shifted.

Top module: `scan_tap_top`

## Requirements
- R1: After power-up reset the controller is in its reset state, `tdo_en` and `dq_hiz` are 0, and the active instruction is the identification opcode 3'b001. A data scan started straight after reset therefore returns the identification word.
- R2: The controller follows the standard sixteen-state graph on `tms`, sampled on the rising edge of `tck`. Five consecutive cycles with `tms`=1 reach the reset state from any state. On the rising edge taken in the reset state, the instruction becomes 3'b001.
- R3: The instruction register is 3 bits wide. Capture-IR loads 3'b001, so the first bit shifted out is 1. Bits shift toward bit 0 with `tdi` entering at bit 2, and the new instruction takes effect at Update-IR.
- R4: Opcodes 3'b000 and 3'b010 select the boundary register and drive `dq_hiz`=1. Opcode 3'b100 selects the boundary register with `dq_hiz`=0. Opcode 3'b001 selects the identification register and 3'b111 selects the pass-through stage, both with `dq_hiz`=0.
- R5: The identification register is 32 bits and is shifted out bit 0 first. Bit 0 is 1, bits 31:28 hold the revision 4'b0111, bits 27:18 hold the part code, bits 17:12 hold the vendor field and bits 11:1 hold the manufacturer code. Data shifted in at `tdi` leaves at `tdo` 32 clocks later.
- R6: The pass-through stage is one bit. It captures 0 in Capture-DR, so the first bit out is 0 and each later bit out is the `tdi` bit of the previous shift clock. It keeps the last bit shifted in.
- R7: The boundary register is BSR_LEN cells long (70 by default). In Capture-DR, cell i loads `pin_sense[i]`, and cell 0 is shifted out first.
- R8: Placeholder cells capture fixed values whatever the pins hold. In the default map, cells 36 and 53 capture 0 and cell 54 captures 1.
- R9: The reserved opcodes 3'b011, 3'b101 and 3'b110 behave exactly like the pass-through opcode and leave `dq_hiz`=0.
- R10: `tdo` and `tdo_en` change only on the falling edge of `tck`. `tdo_en` is 1 exactly while the controller is in Shift-IR or Shift-DR, and `tdo` is 0 whenever `tdo_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| pwr_rst_n | input | 1 | Power-up reset, synchronous, active low |
| tms | input | 1 | Mode select, steers the controller |
| tdi | input | 1 | Serial data in |
| pin_sense | input | BSR_LEN | Pin values captured by the boundary register |
| tdo | output | 1 | Serial data out, launched on the falling edge |
| tdo_en | output | 1 | Serial out drive enable |
| dq_hiz | output | 1 | Tells the data output drivers to float |

## Verification
The bench targets the aliased float opcodes. A decoder that missed one of the two codes would leave the drivers on during a snapshot. It also targets the reserved codes, where a decoder without a fallback would break the chain length. Bypass capture is checked too, because a stage that is not cleared would return a stale first bit. A tour through Pause-DR and Exit2-DR checks that no bit is lost or duplicated across the pause. The five-ones escape from the middle of a scan checks that the instruction really returns to the identification opcode rather than keeping the float opcode. Placeholder cells are scanned with both all-ones and all-zeros pins, which exposes a cell wired to a pin by mistake.

// File: rtl/scan_tap_pkg.sv
// Shared types of the test access port: controller states, opcodes,
// data-path selection and the opcode decode helpers.
package scan_tap_pkg;

    // Controller states; the numeric encoding is internal only
    typedef enum logic [3:0] {
        S_RESET    = 4'h0,
        S_IDLE     = 4'h1,
        S_SEL_DR   = 4'h2,
        S_CAP_DR   = 4'h3,
        S_SHIFT_DR = 4'h4,
        S_EXIT1_DR = 4'h5,
        S_PAUSE_DR = 4'h6,
        S_EXIT2_DR = 4'h7,
        S_UPD_DR   = 4'h8,
        S_SEL_IR   = 4'h9,
        S_CAP_IR   = 4'hA,
        S_SHIFT_IR = 4'hB,
        S_EXIT1_IR = 4'hC,
        S_PAUSE_IR = 4'hD,
        S_EXIT2_IR = 4'hE,
        S_UPD_IR   = 4'hF
    } tap_state_e;

    localparam int OP_W = 3;

    localparam logic [OP_W-1:0] OP_FLOAT_A = 3'b000;
    localparam logic [OP_W-1:0] OP_IDENT   = 3'b001;
    localparam logic [OP_W-1:0] OP_FLOAT_B = 3'b010;
    localparam logic [OP_W-1:0] OP_SNAP    = 3'b100;
    localparam logic [OP_W-1:0] OP_PASS    = 3'b111;

    // Fixed pattern loaded in Capture-IR (two LSBs are 01)
    localparam logic [OP_W-1:0] IR_CAPTURE = 3'b001;

    typedef enum logic [1:0] {
        CH_PASS  = 2'd0,
        CH_IDENT = 2'd1,
        CH_PINS  = 2'd2
    } chain_e;

    // Data path chosen by an opcode; unlisted codes fall back to pass-through
    function automatic chain_e chain_of(input logic [OP_W-1:0] op);
        case (op)
            OP_FLOAT_A, OP_FLOAT_B, OP_SNAP: chain_of = CH_PINS;
            OP_IDENT:                        chain_of = CH_IDENT;
            default:                         chain_of = CH_PASS;
        endcase
    endfunction

    // True for the opcodes that float the data outputs
    function automatic logic floats_outputs(input logic [OP_W-1:0] op);
        floats_outputs = (op == OP_FLOAT_A) || (op == OP_FLOAT_B);
    endfunction

endpackage

// File: rtl/scan_tap_fsm.sv
// Sixteen-state test controller.
// Advances on the rising edge of tck from tms. There is no test-reset pin:
// the synchronous power-up reset and five tms-high cycles are the only
// ways into the reset state.
module scan_tap_fsm
    import scan_tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  logic       tms,
    output tap_state_e state
);

    // Successor of a state for a given tms value
    function automatic tap_state_e succ(input tap_state_e s, input logic m);
        case (s)
            S_RESET:    succ = m ? S_RESET    : S_IDLE;
            S_IDLE:     succ = m ? S_SEL_DR   : S_IDLE;
            S_SEL_DR:   succ = m ? S_SEL_IR   : S_CAP_DR;
            S_CAP_DR:   succ = m ? S_EXIT1_DR : S_SHIFT_DR;
            S_SHIFT_DR: succ = m ? S_EXIT1_DR : S_SHIFT_DR;
            S_EXIT1_DR: succ = m ? S_UPD_DR   : S_PAUSE_DR;
            S_PAUSE_DR: succ = m ? S_EXIT2_DR : S_PAUSE_DR;
            S_EXIT2_DR: succ = m ? S_UPD_DR   : S_SHIFT_DR;
            S_UPD_DR:   succ = m ? S_SEL_DR   : S_IDLE;
            S_SEL_IR:   succ = m ? S_RESET    : S_CAP_IR;
            S_CAP_IR:   succ = m ? S_EXIT1_IR : S_SHIFT_IR;
            S_SHIFT_IR: succ = m ? S_EXIT1_IR : S_SHIFT_IR;
            S_EXIT1_IR: succ = m ? S_UPD_IR   : S_PAUSE_IR;
            S_PAUSE_IR: succ = m ? S_EXIT2_IR : S_PAUSE_IR;
            S_EXIT2_IR: succ = m ? S_UPD_IR   : S_SHIFT_IR;
            S_UPD_IR:   succ = m ? S_SEL_DR   : S_IDLE;
            default:    succ = S_RESET;
        endcase
    endfunction

    // State register, reset state on power-up
    always_ff @(posedge tck) begin
        if (!rst_n) state <= S_RESET;
        else        state <= succ(state, tms);
    end

endmodule

// File: rtl/scan_tap_ir.sv
// Instruction path: a shift stage that captures a fixed pattern, and the
// active instruction loaded at Update-IR. In the reset state the active
// instruction returns to RST_OP.
module scan_tap_ir
    import scan_tap_pkg::*;
#(
    parameter int              IR_W   = OP_W,
    parameter logic [IR_W-1:0] CAP    = IR_CAPTURE,
    parameter logic [IR_W-1:0] RST_OP = OP_IDENT
) (
    input  logic            tck,
    input  logic            rst_n,
    input  tap_state_e      state,
    input  logic            tdi,
    output logic [IR_W-1:0] ir_bits,
    output logic [IR_W-1:0] instr
);

    // Shift stage: capture the pattern, then shift toward bit 0
    always_ff @(posedge tck) begin
        if (!rst_n) begin
            ir_bits <= CAP;
        end else begin
            case (state)
                S_CAP_IR:   ir_bits <= CAP;
                S_SHIFT_IR: ir_bits <= {tdi, ir_bits[IR_W-1:1]};
                default:    ir_bits <= ir_bits;
            endcase
        end
    end

    // Active instruction: default in reset, new value at Update-IR
    always_ff @(posedge tck) begin
        if (!rst_n)                 instr <= RST_OP;
        else if (state == S_RESET)  instr <= RST_OP;
        else if (state == S_UPD_IR) instr <= ir_bits;
    end

endmodule

// File: rtl/scan_tap_dr.sv
// Data paths: a one-bit pass-through stage, the identification word and
// the boundary register. Only the path named by `chain` captures or shifts.
// Boundary cells flagged in PH_MASK capture the matching PH_VAL bit.
module scan_tap_dr
    import scan_tap_pkg::*;
#(
    parameter int                 BSR_LEN = 70,
    parameter int                 ID_W    = 32,
    parameter logic [ID_W-1:0]    ID_WORD = 32'h1,
    parameter logic [BSR_LEN-1:0] PH_MASK = '0,
    parameter logic [BSR_LEN-1:0] PH_VAL  = '0
) (
    input  logic               tck,
    input  logic               rst_n,
    input  tap_state_e         state,
    input  chain_e             chain,
    input  logic               tdi,
    input  logic [BSR_LEN-1:0] pin_sense,
    output logic               dr_lsb
);

    logic               pass_q;
    logic [ID_W-1:0]    id_q;
    logic [BSR_LEN-1:0] bsr_q;
    logic [BSR_LEN-1:0] cap_vec;

    // Per-cell capture source: a pin, or a fixed placeholder level
    for (genvar i = 0; i < BSR_LEN; i++) begin : g_cell
        if (PH_MASK[i]) begin : g_fixed
            assign cap_vec[i] = PH_VAL[i];
        end else begin : g_pin
            assign cap_vec[i] = pin_sense[i];
        end
    end

    // Pass-through stage: cleared on capture, holds the last bit shifted in
    always_ff @(posedge tck) begin
        if (!rst_n) begin
            pass_q <= 1'b0;
        end else if (chain == CH_PASS) begin
            if (state == S_CAP_DR)        pass_q <= 1'b0;
            else if (state == S_SHIFT_DR) pass_q <= tdi;
        end
    end

    // Identification word: load the constant, shift toward bit 0
    always_ff @(posedge tck) begin
        if (!rst_n) begin
            id_q <= ID_WORD;
        end else if (chain == CH_IDENT) begin
            if (state == S_CAP_DR)        id_q <= ID_WORD;
            else if (state == S_SHIFT_DR) id_q <= {tdi, id_q[ID_W-1:1]};
        end
    end

    // Boundary register: snapshot the capture vector, shift toward cell 0
    always_ff @(posedge tck) begin
        if (!rst_n) begin
            bsr_q <= '0;
        end else if (chain == CH_PINS) begin
            if (state == S_CAP_DR)        bsr_q <= cap_vec;
            else if (state == S_SHIFT_DR) bsr_q <= {tdi, bsr_q[BSR_LEN-1:1]};
        end
    end

    // Serial output of the selected path
    always_comb begin
        case (chain)
            CH_IDENT: dr_lsb = id_q[0];
            CH_PINS:  dr_lsb = bsr_q[0];
            default:  dr_lsb = pass_q;
        endcase
    end

endmodule

// File: rtl/scan_tap_top.sv
// Test access port top level.
// Ties the controller, the instruction path and the data paths together,
// decodes the active instruction, and launches tdo and its enable on the
// falling edge of tck. Assumes tms and tdi are stable around rising edges.
module scan_tap_top
    import scan_tap_pkg::*;
#(
    parameter int                 BSR_LEN   = 70,
    parameter logic [3:0]         ID_REV    = 4'b0111,
    parameter logic [9:0]         ID_PART   = 10'b0111010100,
    parameter logic [5:0]         ID_VENDOR = 6'b000000,
    parameter logic [10:0]        ID_MFR    = 11'h0A4,
    parameter logic [BSR_LEN-1:0] PH_MASK   = (BSR_LEN'(1) << 36) |
                                              (BSR_LEN'(1) << 53) |
                                              (BSR_LEN'(1) << 54),
    parameter logic [BSR_LEN-1:0] PH_VAL    = (BSR_LEN'(1) << 54)
) (
    input  logic               tck,
    input  logic               pwr_rst_n,
    input  logic               tms,
    input  logic               tdi,
    input  logic [BSR_LEN-1:0] pin_sense,
    output logic               tdo,
    output logic               tdo_en,
    output logic               dq_hiz
);

    localparam int          ID_W    = 32;
    localparam logic [ID_W-1:0] ID_WORD = {ID_REV, ID_PART, ID_VENDOR, ID_MFR, 1'b1};

    tap_state_e        fsm_state;
    logic [OP_W-1:0]   ir_bits;
    logic [OP_W-1:0]   instr_q;
    chain_e            chain_sel;
    logic              dr_lsb;
    logic              in_shift;
    logic              serial_bit;

    scan_tap_fsm u_fsm (
        .tck   (tck),
        .rst_n (pwr_rst_n),
        .tms   (tms),
        .state (fsm_state)
    );

    scan_tap_ir #(
        .IR_W   (OP_W),
        .CAP    (IR_CAPTURE),
        .RST_OP (OP_IDENT)
    ) u_ir (
        .tck     (tck),
        .rst_n   (pwr_rst_n),
        .state   (fsm_state),
        .tdi     (tdi),
        .ir_bits (ir_bits),
        .instr   (instr_q)
    );

    scan_tap_dr #(
        .BSR_LEN (BSR_LEN),
        .ID_W    (ID_W),
        .ID_WORD (ID_WORD),
        .PH_MASK (PH_MASK),
        .PH_VAL  (PH_VAL)
    ) u_dr (
        .tck       (tck),
        .rst_n     (pwr_rst_n),
        .state     (fsm_state),
        .chain     (chain_sel),
        .tdi       (tdi),
        .pin_sense (pin_sense),
        .dr_lsb    (dr_lsb)
    );

    // Opcode decode: path choice and output float request
    always_comb begin
        chain_sel = chain_of(instr_q);
        dq_hiz    = floats_outputs(instr_q);
    end

    // Bit presented to tdo: instruction or data path, only while shifting
    always_comb begin
        in_shift   = (fsm_state == S_SHIFT_IR) || (fsm_state == S_SHIFT_DR);
        serial_bit = 1'b0;
        if (fsm_state == S_SHIFT_IR)      serial_bit = ir_bits[0];
        else if (fsm_state == S_SHIFT_DR) serial_bit = dr_lsb;
    end

    // Falling-edge launch of the serial output and its enable
    always_ff @(negedge tck) begin
        if (!pwr_rst_n) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo    <= serial_bit;
            tdo_en <= in_shift;
        end
    end

endmodule

// File: rtl/scan_tap_chk.sv
// Property checker for scan_tap_top, attached with bind.
// Observes controller state, instruction path and serial output timing.
module scan_tap_chk
    import scan_tap_pkg::*;
(
    input logic            tck,
    input logic            rst_n,
    input tap_state_e      state,
    input logic [OP_W-1:0] instr,
    input logic [OP_W-1:0] ir_bits,
    input chain_e          chain,
    input logic            dr_lsb,
    input logic            tdo,
    input logic            tdo_en,
    input logic            dq_hiz
);

    // R2
    reset_state_op_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (state == S_RESET) |=> (instr == OP_IDENT));

    // R3
    ir_capture_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (state == S_CAP_IR) |=> (ir_bits == IR_CAPTURE));

    // R4
    float_only_on_update_chk: assert property (@(posedge tck) disable iff (!rst_n)
        $rose(dq_hiz) |-> ($past(state) == S_UPD_IR));

    // R5
    ident_start_bit_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (state == S_CAP_DR && chain == CH_IDENT) |=> (dr_lsb == 1'b1));

    // R6
    pass_cleared_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (state == S_CAP_DR && chain == CH_PASS) |=> (dr_lsb == 1'b0));

    // R10
    tdo_enable_window_chk: assert property (@(posedge tck) disable iff (!rst_n)
        tdo_en == (state == S_SHIFT_IR || state == S_SHIFT_DR));

    // R10
    tdo_quiet_chk: assert property (@(posedge tck) disable iff (!rst_n)
        !tdo_en |-> !tdo);

endmodule

bind scan_tap_top scan_tap_chk u_chk (
    .tck     (tck),
    .rst_n   (pwr_rst_n),
    .state   (fsm_state),
    .instr   (instr_q),
    .ir_bits (ir_bits),
    .chain   (chain_sel),
    .dr_lsb  (dr_lsb),
    .tdo     (tdo),
    .tdo_en  (tdo_en),
    .dq_hiz  (dq_hiz)
);

// File: tb/sim_scan_tap_top.sv
// Bench for scan_tap_top: a behavioural model (queues and integers),
// compared after every falling edge, plus targeted scans per requirement.
module sim_scan_tap_top;

    localparam int  N    = 70;
    localparam time HALF = 2.5ns;

    localparam logic [31:0]  TB_ID  = {4'b0111, 10'b0111010100, 6'b000000, 11'h0A4, 1'b1};
    localparam logic [N-1:0] TB_PHM = (N'(1) << 36) | (N'(1) << 53) | (N'(1) << 54);
    localparam logic [N-1:0] TB_PHV = (N'(1) << 54);

    // model state numbering, independent of the design
    localparam int T_RST = 0,  T_IDL = 1,  T_SDR = 2,  T_CDR = 3,  T_HDR = 4,
                   T_E1D = 5,  T_PDR = 6,  T_E2D = 7,  T_UDR = 8,  T_SIR = 9,
                   T_CIR = 10, T_HIR = 11, T_E1I = 12, T_PIR = 13, T_E2I = 14,
                   T_UIR = 15;

    logic         tck = 1'b0;
    logic         pwr_rst_n = 1'b0;
    logic         tms = 1'b1;
    logic         tdi = 1'b0;
    logic [N-1:0] pin_sense = '0;
    logic         tdo, tdo_en, dq_hiz;

    int n_tests = 0;
    int n_fail  = 0;

    int mst    = T_RST;
    int minstr = 1;
    bit irq[$];
    bit drq[$];
    logic exp_tdo = 1'b0, exp_en = 1'b0, exp_hiz = 1'b0;

    scan_tap_top u0 (
        .tck       (tck),
        .pwr_rst_n (pwr_rst_n),
        .tms       (tms),
        .tdi       (tdi),
        .pin_sense (pin_sense),
        .tdo       (tdo),
        .tdo_en    (tdo_en),
        .dq_hiz    (dq_hiz)
    );

    always #HALF tck = ~tck;

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic int nxt(input int s, input bit m);
        case (s)
            T_RST: return m ? T_RST : T_IDL;
            T_IDL: return m ? T_SDR : T_IDL;
            T_SDR: return m ? T_SIR : T_CDR;
            T_CDR: return m ? T_E1D : T_HDR;
            T_HDR: return m ? T_E1D : T_HDR;
            T_E1D: return m ? T_UDR : T_PDR;
            T_PDR: return m ? T_E2D : T_PDR;
            T_E2D: return m ? T_UDR : T_HDR;
            T_UDR: return m ? T_SDR : T_IDL;
            T_SIR: return m ? T_RST : T_CIR;
            T_CIR: return m ? T_E1I : T_HIR;
            T_HIR: return m ? T_E1I : T_HIR;
            T_E1I: return m ? T_UIR : T_PIR;
            T_PIR: return m ? T_E2I : T_PIR;
            T_E2I: return m ? T_UIR : T_HIR;
            default: return m ? T_SDR : T_IDL;
        endcase
    endfunction

    // Model of one rising edge, using the tms/tdi applied before it
    task automatic model_edge(input bit m, input bit d);
        logic [N-1:0] cap;
        case (mst)
            T_RST: minstr = 1;
            T_CIR: irq = '{1'b1, 1'b0, 1'b0};
            T_HIR: begin irq.push_back(d); void'(irq.pop_front()); end
            T_UIR: minstr = int'(irq[0]) + 2*int'(irq[1]) + 4*int'(irq[2]);
            T_CDR: begin
                drq.delete();
                if (minstr == 1) begin
                    for (int i = 0; i < 32; i++) drq.push_back(TB_ID[i]);
                end else if (minstr == 0 || minstr == 2 || minstr == 4) begin
                    cap = (pin_sense & ~TB_PHM) | (TB_PHV & TB_PHM);
                    for (int i = 0; i < N; i++) drq.push_back(cap[i]);
                end else begin
                    drq.push_back(1'b0);
                end
            end
            T_HDR: begin drq.push_back(d); void'(drq.pop_front()); end
            default: ;
        endcase
        mst     = nxt(mst, m);
        exp_en  = (mst == T_HIR) || (mst == T_HDR);
        exp_tdo = (mst == T_HIR) ? irq[0] : (mst == T_HDR) ? drq[0] : 1'b0;
        exp_hiz = (minstr == 0) || (minstr == 2);
    endtask

    // One clock: check after the falling edge, drive, model the rising edge
    task automatic step(input bit m, input bit d, output logic seen);
        @(negedge tck); #1;
        seen = tdo;
        chk(tdo_en === exp_en,  "R10 tdo_en", tdo_en, exp_en);
        chk(tdo === exp_tdo,    "R10 tdo",    tdo,    exp_tdo);
        chk(dq_hiz === exp_hiz, "R4 dq_hiz",  dq_hiz, exp_hiz);
        tms = m;
        tdi = d;
        @(posedge tck); #1;
        model_edge(m, d);
    endtask

    // From Run-Test/Idle: load an opcode, return the captured IR bits
    task automatic load_ir(input logic [2:0] op, output logic [2:0] cap);
        logic s;
        step(1, 0, s); step(1, 0, s); step(0, 0, s); step(0, 0, s);
        for (int i = 0; i < 3; i++) begin
            step(i == 2, op[i], s);
            cap[i] = s;
        end
        step(1, 0, s); step(0, 0, s);
    endtask

    // From Run-Test/Idle: scan n bits through the selected data path
    task automatic scan_dr(input int n, input logic [127:0] din, output logic [127:0] dout);
        logic s;
        dout = '0;
        step(1, 0, s); step(0, 0, s); step(0, 0, s);
        for (int i = 0; i < n; i++) begin
            step(i == n - 1, din[i], s);
            dout[i] = s;
        end
        step(1, 0, s); step(0, 0, s);
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        #(HALF * 2 * 150000);
        n_fail++;
        $display("FAIL R10 watchdog act=running exp=finished");
        summary();
        $finish;
    end

    initial begin
        logic [2:0]   ircap;
        logic [127:0] got;
        logic [N-1:0] expc;
        logic         s;

        // R1: reset state while reset is held
        repeat (3) @(posedge tck);
        @(negedge tck); #1;
        chk(tdo_en === 1'b0, "R1 tdo_en in reset", tdo_en, 1'b0);
        chk(dq_hiz === 1'b0, "R1 dq_hiz in reset", dq_hiz, 1'b0);
        chk(tdo === 1'b0,    "R1 tdo in reset",    tdo,    1'b0);
        @(posedge tck); #1;
        pwr_rst_n = 1'b1;

        // R1 / R5: identification word right after reset
        step(0, 0, s);
        scan_dr(32, '0, got);
        chk(got[31:0] === TB_ID, "R1 R5 ident after reset", got[31:0], TB_ID);
        chk(got[0] === 1'b1, "R5 start bit", got[0], 1'b1);
        chk(got[31:28] === 4'b0111, "R5 revision", got[31:28], 4'b0111);

        // R5: data shifted in leaves 32 clocks later
        scan_dr(40, 128'hC6, got);
        chk(got[39:32] === 8'hC6, "R5 shift-through", got[39:32], 8'hC6);

        // R3 / R6: pass-through opcode
        load_ir(3'b111, ircap);
        chk(ircap === 3'b001, "R3 IR capture", ircap, 3'b001);
        scan_dr(4, 128'b1101, got);
        chk(got[3:0] === 4'b1010, "R6 pass-through delay", got[3:0], 4'b1010);
        scan_dr(4, 128'b1101, got);
        chk(got[0] === 1'b0, "R6 cleared on capture", got[0], 1'b0);

        // R4 / R7 / R8: plain snapshot, outputs stay driven
        load_ir(3'b100, ircap);
        chk(dq_hiz === 1'b0, "R4 snapshot keeps drivers", dq_hiz, 1'b0);
        pin_sense = 70'h2B_96E1_0F78_5AC3_D41;
        expc = (pin_sense & ~TB_PHM) | TB_PHV;
        scan_dr(N, '0, got);
        chk(got[N-1:0] === expc, "R7 snapshot pattern A", got[N-1:0], expc);

        // R4: both float aliases
        load_ir(3'b000, ircap);
        @(negedge tck); #1;
        chk(dq_hiz === 1'b1, "R4 float opcode 000", dq_hiz, 1'b1);
        pin_sense = ~pin_sense;
        expc = (pin_sense & ~TB_PHM) | TB_PHV;
        scan_dr(N, '0, got);
        chk(got[N-1:0] === expc, "R7 snapshot pattern B", got[N-1:0], expc);
        load_ir(3'b010, ircap);
        @(negedge tck); #1;
        chk(dq_hiz === 1'b1, "R4 float opcode 010", dq_hiz, 1'b1);

        // R8: placeholders against all-ones and all-zeros pins
        pin_sense = '1;
        scan_dr(N, '0, got);
        chk({got[54], got[53], got[36]} === 3'b100, "R8 placeholders pins=1",
            {got[54], got[53], got[36]}, 3'b100);
        pin_sense = '0;
        scan_dr(N, '0, got);
        chk({got[54], got[53], got[36]} === 3'b100, "R8 placeholders pins=0",
            {got[54], got[53], got[36]}, 3'b100);

        // R9: reserved opcodes behave as pass-through
        for (int k = 0; k < 3; k++) begin
            logic [2:0] rop;
            rop = (k == 0) ? 3'b011 : (k == 1) ? 3'b101 : 3'b110;
            load_ir(rop, ircap);
            @(negedge tck); #1;
            chk(dq_hiz === 1'b0, "R9 reserved no float", dq_hiz, 1'b0);
            scan_dr(3, 128'b011, got);
            chk(got[2:0] === 3'b110, "R9 reserved pass-through", got[2:0], 3'b110);
        end

        // R10: pause inside a data scan loses no bit
        load_ir(3'b001, ircap);
        step(1, 0, s); step(0, 0, s); step(0, 0, s);
        step(0, 0, s);
        step(1, 0, s);
        step(0, 0, s); step(0, 0, s);
        step(1, 0, s);
        step(0, 0, s);
        step(1, 0, s);
        chk(s === TB_ID[2], "R10 bit after pause", s, TB_ID[2]);
        step(1, 0, s); step(0, 0, s);

        // R2: five ones from mid-scan restore the identification opcode
        load_ir(3'b000, ircap);
        step(1, 0, s); step(0, 0, s); step(0, 0, s);
        repeat (5) step(1, 0, s);
        step(1, 0, s);
        step(0, 0, s);
        @(negedge tck); #1;
        chk(dq_hiz === 1'b0, "R2 escape clears float", dq_hiz, 1'b0);
        scan_dr(32, '0, got);
        chk(got[31:0] === TB_ID, "R2 ident after escape", got[31:0], TB_ID);

        summary();
        $finish;
    end

endmodule